// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table from memory. A first-level entry either maps a whole 1 MB region directly or points to a second-level table. There are two kinds of second-level table: a 1 KB one with 256 entries and a 4 KB one with 1024 entries. A second-level entry maps a 64 KB, 4 KB or 1 KB page. After the address is resolved, the walker reads the two-bit access type of the entry's domain from a 16-domain control word. When that access type asks for it, the walker also checks the two-bit permission of the entry against the privilege and write flags of the request.

A requester raises `req_valid` while `req_ready` is high. The walker then issues one or two single-word memory reads, one at a time. Each read is a one-cycle `mem_req` pulse, answered after any number of cycles by a one-cycle `mem_rvalid`. At the end the walker pulses `done` for one cycle. During that pulse it presents either the physical address or a fault with its class. No translations are stored, and cache attribute bits are ignored.

Top module: `mmu_walker`

## Requirements
- R1: The first read of each walk goes to address {ttb_base[31:14], vaddr[31:20], 2'b00}. Bits 13:0 of ttb_base are ignored.
- R2: A first-level entry whose bits 1:0 are 00 ends the walk with fault code 1 (level-one translation fault) and no second read.
- R3: A first-level entry with bits 1:0 = 10 maps a 1 MB region. The physical address is {entry[31:20], vaddr[19:0]}, the permission is entry[11:10] and the domain is entry[8:5].
- R4: A first-level entry with bits 1:0 = 01 leads to a second read at {entry[31:10], vaddr[19:12], 2'b00}. In that second entry, type 01 gives a 64 KB page {d[31:16], vaddr[15:0]} and type 10 gives a 4 KB page {d[31:12], vaddr[11:0]}. The permission is the two-bit field at d[5+2k:4+2k]. For a 64 KB page, k = vaddr[15:14]. For a 4 KB page, k = vaddr[11:10].
- R5: A first-level entry with bits 1:0 = 11 leads to a second read at {entry[31:12], vaddr[19:10], 2'b00}. A second entry of type 11 gives a 1 KB page {d[31:10], vaddr[9:0]} with permission d[5:4].
- R6: A second-level entry whose bits 1:0 are 00 ends the walk with fault code 2 (level-two translation fault).
- R7: The domain access type is dacr[2*dom+1:2*dom]. Value 00 (no access) and value 10 (reserved) give fault code 3. Value 11 (manager) passes whatever the permission. Value 01 (client) applies R8.
- R8: Permission 00 allows only a privileged read. Permission 01 allows privileged reads and writes. Permission 10 also allows unprivileged reads. Permission 11 allows everything. A denied access gives fault code 4.
- R9: `done` is high for exactly one cycle per accepted request. A successful walk shows fault = 0, fault_code = 0 and the translated `pa`. A faulting walk shows fault = 1 and `pa` = 0.
- R10: Requests are accepted only while `req_ready` is high, which is only when idle. Each `mem_req` is a single-cycle pulse, and no new read is issued until the previous one has returned `mem_rvalid`.
- R11: After reset, `req_ready` is 1 and `done` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ttb_base | input | 32 | First-level table base; bits 31:14 used |
| dacr | input | 32 | Sixteen two-bit domain access types |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_priv | input | 1 | Request is privileged |
| req_write | input | 1 | Request is a write |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Byte address of the descriptor word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor word read back |
| done | output | 1 | One-cycle completion pulse |
| pa | output | 32 | Physical address (zero on a fault) |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 3 | 0 none, 1 L1 translation, 2 L2 translation, 3 domain, 4 permission |

## Verification
The hardest case to reach is subpage selection inside a 64 KB page. The index bits that pick the permission field also feed the second-level table index. The bench therefore fills all sixteen replicated entries of the page with the same descriptor, which has four different permission fields, and walks addresses that differ only in bits 15:14. The memory model also changes its response delay on every read, from zero to four cycles. This makes the walker wait for `mem_rvalid` under several different latencies.

// File: rtl/mmu_walk_pkg.sv
// Shared types of the translation walker: walk states, fault classes and
// the first-level entry kinds (the kind values are the entry's bits 1:0).
package mmu_walk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_L1_REQ  = 3'd1,
        ST_L1_WAIT = 3'd2,
        ST_L2_REQ  = 3'd3,
        ST_L2_WAIT = 3'd4,
        ST_CHECK   = 3'd5,
        ST_DONE    = 3'd6
    } walk_state_e;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_XLATE_L1 = 3'd1,
        FLT_XLATE_L2 = 3'd2,
        FLT_DOMAIN   = 3'd3,
        FLT_PERM     = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        L1K_FAULT   = 2'b00,
        L1K_COARSE  = 2'b01,
        L1K_SECTION = 2'b10,
        L1K_FINE    = 2'b11
    } l1_kind_e;

endpackage

// File: rtl/mmu_l1_decode.sv
// First-level entry decoder. It is purely combinational.
// Assumes: the entry word comes straight from the memory port. Only the
// low 20 address bits are needed here; the caller builds the L1 address.
module mmu_l1_decode
    import mmu_walk_pkg::*;
(
    input  logic [31:0] desc,
    input  logic [19:0] va_low,
    output l1_kind_e    kind,
    output logic [31:0] sect_pa,
    output logic [31:0] l2_addr,
    output logic [3:0]  dom,
    output logic [1:0]  sect_ap
);

    logic unused_desc_bits;

    assign kind    = l1_kind_e'(desc[1:0]);
    assign sect_pa = {desc[31:20], va_low};
    assign sect_ap = desc[11:10];
    assign dom     = desc[8:5];
    assign unused_desc_bits = ^{desc[9], desc[4:2]};

    // Second-level entry address: the fine table is 4 KB, the coarse table is 1 KB
    always_comb begin
        if (desc[1:0] == L1K_FINE)
            l2_addr = {desc[31:12], va_low[19:10], 2'b00};
        else
            l2_addr = {desc[31:10], va_low[19:12], 2'b00};
    end

endmodule

// File: rtl/mmu_l2_decode.sv
// Second-level entry decoder. It is purely combinational.
// Assumes: the entry word comes straight from the memory port. For 64 KB
// and 4 KB pages the permission is taken from one of four subpage fields.
module mmu_l2_decode #(
    parameter int unsigned SUBPAGES = 4
) (
    input  logic [31:0] desc,
    input  logic [15:0] va_low,
    output logic        is_fault,
    output logic [31:0] pa,
    output logic [1:0]  ap
);

    localparam int unsigned SP_W = $clog2(SUBPAGES);

    logic [1:0] sp_ap [SUBPAGES];
    logic       unused_desc_bits;

    assign unused_desc_bits = ^desc[3:2];

    // Split the four subpage permission fields out of the entry
    for (genvar g = 0; g < SUBPAGES; g++) begin : g_subpage
        assign sp_ap[g] = desc[4 + 2*g +: 2];
    end

    // Page size select: base width and permission source
    always_comb begin
        is_fault = 1'b0;
        pa       = '0;
        ap       = 2'b00;
        unique case (desc[1:0])
            2'b01: begin
                pa = {desc[31:16], va_low[15:0]};
                ap = sp_ap[va_low[15:14]];
            end
            2'b10: begin
                pa = {desc[31:12], va_low[11:0]};
                ap = sp_ap[SP_W'(va_low[11:10])];
            end
            2'b11: begin
                pa = {desc[31:10], va_low[9:0]};
                ap = sp_ap[0];
            end
            default: is_fault = 1'b1;
        endcase
    end

endmodule

// File: rtl/mmu_perm_check.sv
// Domain and permission checker. It is combinational; the clock is used
// only by its assertions.
// Assumes: check_en is high only in the cycle the walker evaluates the result.
module mmu_perm_check #(
    parameter int unsigned NUM_DOM = 16,
    localparam int unsigned DOM_W  = $clog2(NUM_DOM),
    localparam int unsigned DACR_W = 2 * NUM_DOM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              check_en,
    input  logic [DACR_W-1:0] dacr,
    input  logic [DOM_W-1:0]  dom,
    input  logic [1:0]        ap,
    input  logic              priv,
    input  logic              write,
    output logic              dom_fault,
    output logic              perm_fault
);

    logic [1:0] dom_acc;
    logic       allowed;

    assign dom_acc = dacr[{dom, 1'b0} +: 2];

    // Permission table lookup for a client domain
    always_comb begin
        unique case (ap)
            2'b00:   allowed = priv && !write;
            2'b01:   allowed = priv;
            2'b10:   allowed = priv || !write;
            default: allowed = 1'b1;
        endcase
    end

    // Access type decides between deny, bypass and permission check
    always_comb begin
        dom_fault  = 1'b0;
        perm_fault = 1'b0;
        unique case (dom_acc)
            2'b01:   perm_fault = !allowed;
            2'b11:   perm_fault = 1'b0;
            default: dom_fault  = 1'b1;
        endcase
    end

    AST_MANAGER_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        check_en && dom_acc == 2'b11 |-> !dom_fault && !perm_fault); // R7
    AST_USER_WRITE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        check_en && dom_acc == 2'b01 && !priv && write && ap != 2'b11 |-> perm_fault); // R8

endmodule

// File: rtl/mmu_walker.sv
// Two-level translation table walker.
// Sequence: accept in idle, read the first-level entry, then either go
// straight to the check or read one second-level entry, then pulse done.
// Assumes: the memory answers every request exactly once with mem_rvalid,
// after any delay, and never sends mem_rvalid unrequested.
module mmu_walker
    import mmu_walk_pkg::*;
#(
    parameter int unsigned NUM_DOM = 16,
    localparam int unsigned DOM_W  = $clog2(NUM_DOM),
    localparam int unsigned DACR_W = 2 * NUM_DOM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       ttb_base,
    input  logic [DACR_W-1:0] dacr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_vaddr,
    input  logic              req_priv,
    input  logic              req_write,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output logic [31:0]       pa,
    output logic              fault,
    output logic [2:0]        fault_code
);

    walk_state_e       state;
    logic [31:0]       va_r;
    logic              priv_r;
    logic              write_r;
    logic [17:0]       ttb_r;
    logic [DACR_W-1:0] dacr_r;
    logic [DOM_W-1:0]  dom_r;
    logic [1:0]        ap_r;
    logic [31:0]       pa_r;
    logic [31:0]       l2_addr_r;
    fault_e            fault_r;

    l1_kind_e          l1_kind;
    logic [31:0]       l1_sect_pa;
    logic [31:0]       l1_l2_addr;
    logic [3:0]        l1_dom;
    logic [1:0]        l1_ap;
    logic              l2_fault;
    logic [31:0]       l2_pa;
    logic [1:0]        l2_ap;
    logic              dom_fault;
    logic              perm_fault;
    logic              unused_ttb_low;

    assign unused_ttb_low = ^ttb_base[13:0];

    mmu_l1_decode u_l1 (
        .desc    (mem_rdata),
        .va_low  (va_r[19:0]),
        .kind    (l1_kind),
        .sect_pa (l1_sect_pa),
        .l2_addr (l1_l2_addr),
        .dom     (l1_dom),
        .sect_ap (l1_ap)
    );

    mmu_l2_decode #(.SUBPAGES(4)) u_l2 (
        .desc     (mem_rdata),
        .va_low   (va_r[15:0]),
        .is_fault (l2_fault),
        .pa       (l2_pa),
        .ap       (l2_ap)
    );

    mmu_perm_check #(.NUM_DOM(NUM_DOM)) u_chk (
        .clk        (clk),
        .rst_n      (rst_n),
        .check_en   (state == ST_CHECK),
        .dacr       (dacr_r),
        .dom        (dom_r),
        .ap         (ap_r),
        .priv       (priv_r),
        .write      (write_r),
        .dom_fault  (dom_fault),
        .perm_fault (perm_fault)
    );

    assign req_ready  = (state == ST_IDLE);
    assign mem_req    = (state == ST_L1_REQ) || (state == ST_L2_REQ);
    assign mem_addr   = (state == ST_L1_REQ) ? {ttb_r, va_r[31:20], 2'b00} : l2_addr_r;
    assign done       = (state == ST_DONE);
    assign pa         = pa_r;
    assign fault      = (fault_r != FLT_NONE);
    assign fault_code = fault_r;

    // Walk sequencer: latches the request, consumes entries, records the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            va_r      <= '0;
            priv_r    <= 1'b0;
            write_r   <= 1'b0;
            ttb_r     <= '0;
            dacr_r    <= '0;
            dom_r     <= '0;
            ap_r      <= '0;
            pa_r      <= '0;
            l2_addr_r <= '0;
            fault_r   <= FLT_NONE;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    va_r    <= req_vaddr;
                    priv_r  <= req_priv;
                    write_r <= req_write;
                    ttb_r   <= ttb_base[31:14];
                    dacr_r  <= dacr;
                    fault_r <= FLT_NONE;
                    pa_r    <= '0;
                    state   <= ST_L1_REQ;
                end
                ST_L1_REQ: state <= ST_L1_WAIT;
                ST_L1_WAIT: if (mem_rvalid) begin
                    dom_r <= DOM_W'(l1_dom);
                    unique case (l1_kind)
                        L1K_FAULT: begin
                            fault_r <= FLT_XLATE_L1;
                            pa_r    <= '0;
                            state   <= ST_DONE;
                        end
                        L1K_SECTION: begin
                            pa_r  <= l1_sect_pa;
                            ap_r  <= l1_ap;
                            state <= ST_CHECK;
                        end
                        default: begin
                            l2_addr_r <= l1_l2_addr;
                            state     <= ST_L2_REQ;
                        end
                    endcase
                end
                ST_L2_REQ: state <= ST_L2_WAIT;
                ST_L2_WAIT: if (mem_rvalid) begin
                    if (l2_fault) begin
                        fault_r <= FLT_XLATE_L2;
                        pa_r    <= '0;
                        state   <= ST_DONE;
                    end else begin
                        pa_r  <= l2_pa;
                        ap_r  <= l2_ap;
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (dom_fault) begin
                        fault_r <= FLT_DOMAIN;
                        pa_r    <= '0;
                    end else if (perm_fault) begin
                        fault_r <= FLT_PERM;
                        pa_r    <= '0;
                    end
                    state <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> pa == 32'd0); // R9
    AST_MEM_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready); // R10
    AST_L1_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> mem_req && mem_addr[13:2] == $past(req_vaddr[31:20])); // R1

endmodule

// File: tb/mmu_walker_tb.sv
// Scoreboard bench: the driver queues expected results, the monitor
// compares them on each done pulse; a latency-varying memory model serves tables.
module mmu_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ttb_base = 32'h0012_3ABC;
    logic [31:0] dacr = 32'h0000_008D;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_priv = 1'b0;
    logic        req_write = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] pa;
    logic        fault;
    logic [2:0]  fault_code;

    int checks = 0;
    int fails = 0;

    typedef struct {
        logic [31:0] pa;
        logic [2:0]  code;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    logic [31:0] mem_tbl [int unsigned];
    bit          l1_pending = 1'b0;
    logic [31:0] l1_expect = '0;
    bit          rd_busy = 1'b0;
    int          rd_cnt = 0;
    logic [31:0] rd_addr = '0;
    int          delay_sel = 0;

    always #2.5 clk = ~clk;

    mmu_walker u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ttb_base   (ttb_base),
        .dacr       (dacr),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .req_priv   (req_priv),
        .req_write  (req_write),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .pa         (pa),
        .fault      (fault),
        .fault_code (fault_code)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: one read at a time, response delay cycles through 0..4
    always @(negedge clk) begin
        mem_rvalid <= 1'b0;
        if (rst_n) begin
            if (rd_busy) begin
                if (rd_cnt == 0) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= mem_tbl.exists(rd_addr) ? mem_tbl[rd_addr] : 32'h0;
                    rd_busy = 1'b0;
                end else begin
                    rd_cnt--;
                end
            end
            if (mem_req) begin
                check(!rd_busy, "R10 overlapping read", {31'd0, rd_busy}, 32'd0);
                if (l1_pending) begin
                    check(mem_addr == l1_expect, "R1 first-level address", mem_addr, l1_expect);
                    l1_pending = 1'b0;
                end
                rd_busy = 1'b1;
                rd_addr = mem_addr;
                rd_cnt  = delay_sel % 5;
                delay_sel++;
            end
        end
    end

    // Monitor: pops an expected item on each done pulse and compares it
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R9 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(fault_code == e.code, {e.tag, " code"}, {29'd0, fault_code}, {29'd0, e.code});
                check(pa == e.pa, {e.tag, " pa"}, pa, e.pa);
                check(fault == (e.code != 3'd0), {e.tag, " fault flag"}, {31'd0, fault}, {31'd0, e.code != 3'd0});
            end
        end
    end

    // Driver: queues the expected result and hands the request over
    task automatic walk(input logic [31:0] va, input bit priv, input bit wr,
                        input logic [31:0] exp_pa, input logic [2:0] exp_code, input string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.pa = exp_pa; e.code = exp_code; e.tag = tag;
        sb_q.push_back(e);
        l1_expect  = {ttb_base[31:14], va[31:20], 2'b00};
        l1_pending = 1'b1;
        req_vaddr  = va;
        req_priv   = priv;
        req_write  = wr;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        check(!req_ready, "R10 ready low while busy", {31'd0, req_ready}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (R10 walk hung) actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stimulus
        // First-level table at 0x00120000, indexed by vaddr[31:20]
        mem_tbl[32'h0012_0004] = 32'h8000_0402; // section, dom0, perm 01
        mem_tbl[32'h0012_0008] = 32'h9010_0022; // section, dom1 manager, perm 00
        mem_tbl[32'h0012_000C] = 32'hA000_0C42; // section, dom2 no access
        mem_tbl[32'h0012_0010] = 32'hA010_0C62; // section, dom3 reserved
        mem_tbl[32'h0012_0014] = 32'h0020_0401; // coarse table 0x00200400
        mem_tbl[32'h0012_0018] = 32'h0030_0003; // fine table 0x00300000
        mem_tbl[32'h0012_0020] = 32'hB000_0802; // section perm 10
        mem_tbl[32'h0012_0024] = 32'hB010_0C02; // section perm 11
        mem_tbl[32'h0012_0028] = 32'hB020_0002; // section perm 00
        // Coarse table: 64 KB page replicated over entries 0x10..0x1F, subpage perms 00,01,10,11
        for (int i = 16; i < 32; i++) mem_tbl[32'h0020_0400 + 4*i] = 32'hC001_0E41;
        mem_tbl[32'h0020_0480] = 32'hC020_0932; // 4 KB page, subpage perms 11,00,01,10
        mem_tbl[32'h0030_0014] = 32'hD000_0423; // fine table entry 5: 1 KB page perm 10

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R11 reset ready", {31'd0, req_ready}, 32'd1);
        check(done == 1'b0, "R11 reset done", {31'd0, done}, 32'd0);
        check(mem_req == 1'b0, "R11 reset mem_req", {31'd0, mem_req}, 32'd0);

        walk(32'h0011_2345, 1, 0, 32'h8001_2345, 3'd0, "R3 section priv read");
        walk(32'h0011_2345, 1, 1, 32'h8001_2345, 3'd0, "R3 section priv write");
        walk(32'h0011_2345, 0, 0, 32'h0,         3'd4, "R8 perm01 user read");
        walk(32'h002A_BCDE, 0, 1, 32'h901A_BCDE, 3'd0, "R7 manager bypass");
        walk(32'h0030_0000, 1, 0, 32'h0,         3'd3, "R7 no-access domain");
        walk(32'h0040_0010, 1, 0, 32'h0,         3'd3, "R7 reserved domain");
        walk(32'h0070_0000, 1, 0, 32'h0,         3'd1, "R2 L1 fault");
        walk(32'h0080_0004, 0, 0, 32'hB000_0004, 3'd0, "R8 perm10 user read");
        walk(32'h0080_0004, 0, 1, 32'h0,         3'd4, "R8 perm10 user write");
        walk(32'h0080_0004, 1, 1, 32'hB000_0004, 3'd0, "R8 perm10 priv write");
        walk(32'h0090_0008, 0, 1, 32'hB010_0008, 3'd0, "R8 perm11 user write");
        walk(32'h00A0_000C, 1, 0, 32'hB020_000C, 3'd0, "R8 perm00 priv read");
        walk(32'h00A0_000C, 1, 1, 32'h0,         3'd4, "R8 perm00 priv write");
        walk(32'h0051_C123, 0, 1, 32'hC001_C123, 3'd0, "R4 large sp3");
        walk(32'h0051_4000, 0, 0, 32'h0,         3'd4, "R4 large sp1");
        walk(32'h0051_8000, 0, 0, 32'hC001_8000, 3'd0, "R4 large sp2 read");
        walk(32'h0051_8000, 0, 1, 32'h0,         3'd4, "R4 large sp2 write");
        walk(32'h0051_0000, 1, 0, 32'hC001_0000, 3'd0, "R4 large sp0 read");
        walk(32'h0051_0000, 1, 1, 32'h0,         3'd4, "R4 large sp0 write");
        walk(32'h0052_0ABC, 1, 1, 32'hC020_0ABC, 3'd0, "R4 small sp2 priv write");
        walk(32'h0052_0ABC, 0, 0, 32'h0,         3'd4, "R4 small sp2 user read");
        walk(32'h0052_0123, 0, 1, 32'hC020_0123, 3'd0, "R4 small sp0 user write");
        walk(32'h0052_0C00, 0, 0, 32'hC020_0C00, 3'd0, "R4 small sp3 user read");
        walk(32'h0053_0000, 1, 0, 32'h0,         3'd2, "R6 L2 fault coarse");
        walk(32'h0060_17FF, 0, 0, 32'hD000_07FF, 3'd0, "R5 tiny user read");
        walk(32'h0060_17FF, 0, 1, 32'h0,         3'd4, "R5 tiny user write");
        walk(32'h0060_1000, 1, 0, 32'h0,         3'd2, "R6 L2 fault fine");

        while (sb_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(done == 1'b0, "R9 no extra done", {31'd0, done}, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule